// File: doc/BRIEF.md
# Pipelined Multiplier Modulo 65537

This block multiplies two 16-bit operands modulo 2^16+1, as needed by 64-bit block ciphers that work on 16-bit subblocks. In that convention a 16-bit operand code of 0x0000 does not mean zero; it stands for the value 65536. Results are encoded the same way: a reduced product of 65536 leaves the block as 0x0000.

The multiplier is fully pipelined. It accepts one operand pair on every clock, marked by a valid flag, and returns the product four cycles later with a matching valid flag. The partial products are summed by a registered three-level adder tree. A final stage folds the 32-bit product into the modulus by subtracting its upper half from its lower half. Operands that carry the 65536 code skip the tree and are handled in that final stage.

Top module: `mm_mul65537`

## Requirements
- R1: For two nonzero operand codes a and b, the output equals (a*b) mod 65537, encoded in 16 bits.
- R2: An operand code of 0x0000 is taken as 65536, so with exactly one such operand and other operand x the result is (65537 - x) mod 65537, encoded in 16 bits.
- R3: When both operand codes are 0x0000, the result is 0x0001.
- R4: A reduced product equal to 65536, for example 0x0002 times 0x8000, is emitted as 0x0000.
- R5: An operand code of 0x0001 returns the other operand code unchanged.
- R6: A new operand pair is accepted on every clock cycle, and pairs sent back to back each produce their own result in order.
- R7: out_valid_o is high exactly four clock cycles after in_valid_i was high at a rising edge, and is low otherwise.
- R8: While rst_ni is low, out_valid_o is low, and no result from before the reset appears after it is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Operand pair present this cycle |
| a_i | input | 16 | First operand code (0x0000 means 65536) |
| b_i | input | 16 | Second operand code (0x0000 means 65536) |
| out_valid_o | output | 1 | Result present this cycle |
| prod_o | output | 16 | Product modulo 65537 (0x0000 means 65536) |

## Verification
On every cycle the assertions check that the output valid flag tracks the input flag with the four-cycle delay and stays low in reset, and that the special operand classes give their fixed answers: both zero codes yield one, a single zero code yields the negated other operand, a unit operand passes the other through, and 2 times 0x8000 yields the zero code. Only the bench scenarios show that general nonzero products reduce correctly across the whole operand range, that results stay in order under back-to-back and gapped traffic, and that a reset issued while the pipeline is full discards the results in flight.

// File: rtl/mm_pkg.sv
package mm_pkg;
  parameter int unsigned MM_W = 16;
  localparam int unsigned MM_PW = 2 * MM_W;
  localparam int unsigned MM_TREE_LAT = 3;
  localparam int unsigned MM_LAT = MM_TREE_LAT + 1;

  typedef logic [MM_W-1:0]  opnd_t;
  typedef logic [MM_PW-1:0] wide_t;

  // operands carried around the adder tree for the zero-code bypass
  typedef struct packed {
    logic  az;
    logic  bz;
    opnd_t other;
  } side_t;
endpackage

// File: rtl/mm_pp_tree.sv
module mm_pp_tree
  import mm_pkg::*;
(
  input  logic  clk_i,
  input  opnd_t a_i,
  input  opnd_t b_i,
  output wide_t prod_o
);
  localparam int unsigned NPP = MM_W;
  localparam int unsigned L1_N = 4;
  localparam int unsigned GRP = NPP / L1_N;
  localparam int unsigned L2_N = L1_N / 2;

  wide_t pp [NPP];

  for (genvar i = 0; i < NPP; i++) begin : g_pp
    assign pp[i] = b_i[i] ? (wide_t'({{MM_W{1'b0}}, a_i}) << i) : '0;
  end

  wide_t l1_d [L1_N];
  wide_t l1_q [L1_N];
  wide_t l2_d [L2_N];
  wide_t l2_q [L2_N];
  wide_t l3_q;

  always_comb begin
    for (int g = 0; g < L1_N; g++) begin
      l1_d[g] = '0;
      for (int k = 0; k < GRP; k++) l1_d[g] = l1_d[g] + pp[g*GRP + k];
    end
  end

  always_comb begin
    for (int g = 0; g < L2_N; g++) l2_d[g] = l1_q[2*g] + l1_q[2*g + 1];
  end

  always_ff @(posedge clk_i) begin
    l1_q <= l1_d;
    l2_q <= l2_d;
    l3_q <= l2_q[0] + l2_q[1];
  end

  assign prod_o = l3_q;
endmodule

// File: rtl/mm_side_pipe.sv
module mm_side_pipe
  import mm_pkg::*;
#(
  parameter int unsigned DEPTH = MM_TREE_LAT
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  valid_i,
  input  side_t side_i,
  output logic  valid_o,
  output side_t side_o
);
  for (genvar s = 0; s < DEPTH; s++) begin : g_stage
    logic  d_v;
    side_t d_side;
    logic  v_q;
    side_t side_q;

    if (s == 0) begin : g_first
      assign d_v    = valid_i;
      assign d_side = side_i;
    end else begin : g_next
      assign d_v    = g_stage[s-1].v_q;
      assign d_side = g_stage[s-1].side_q;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) v_q <= 1'b0;
      else         v_q <= d_v;
    end

    always_ff @(posedge clk_i) side_q <= d_side;
  end

  assign valid_o = g_stage[DEPTH-1].v_q;
  assign side_o  = g_stage[DEPTH-1].side_q;
endmodule

// File: rtl/mm_reduce.sv
module mm_reduce
  import mm_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  valid_i,
  input  wide_t prod_i,
  input  side_t side_i,
  output logic  valid_o,
  output opnd_t res_o
);
  opnd_t lo, hi, res_d;
  logic  borrow;

  always_comb begin
    lo     = prod_i[MM_W-1:0];
    hi     = prod_i[MM_PW-1:MM_W];
    borrow = lo < hi;
    if (side_i.az && side_i.bz)
      res_d = opnd_t'(1);
    else if (side_i.az || side_i.bz)
      res_d = opnd_t'(1) - side_i.other;  // 65537 - x, 65536 wraps to code 0
    else
      res_d = lo - hi + {{(MM_W-1){1'b0}}, borrow};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_o <= 1'b0;
    else         valid_o <= valid_i;
  end

  always_ff @(posedge clk_i) res_o <= res_d;
endmodule

// File: rtl/mm_mul65537.sv
module mm_mul65537
  import mm_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        in_valid_i,
  input  logic [15:0] a_i,
  input  logic [15:0] b_i,
  output logic        out_valid_o,
  output logic [15:0] prod_o
);
  side_t side_in, side_dly;
  wide_t prod_raw;
  logic  valid_dly;

  assign side_in.az    = (a_i == '0);
  assign side_in.bz    = (b_i == '0);
  assign side_in.other = side_in.az ? b_i : a_i;

  mm_pp_tree u_tree (
    .clk_i  (clk_i),
    .a_i    (a_i),
    .b_i    (b_i),
    .prod_o (prod_raw)
  );

  mm_side_pipe #(.DEPTH(MM_TREE_LAT)) u_side (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (in_valid_i),
    .side_i  (side_in),
    .valid_o (valid_dly),
    .side_o  (side_dly)
  );

  mm_reduce u_red (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_dly),
    .prod_i  (prod_raw),
    .side_i  (side_dly),
    .valid_o (out_valid_o),
    .res_o   (prod_o)
  );
endmodule

// File: rtl/mm_chk.sv
module mm_chk
  import mm_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input logic        in_valid_i,
  input logic [15:0] a_i,
  input logic [15:0] b_i,
  input logic        out_valid_o,
  input logic [15:0] prod_o
);
  logic  vq [MM_LAT];
  opnd_t aq [MM_LAT];
  opnd_t bq [MM_LAT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < MM_LAT; i++) vq[i] <= 1'b0;
    end else begin
      vq[0] <= in_valid_i;
      for (int i = 1; i < MM_LAT; i++) vq[i] <= vq[i-1];
    end
  end

  always_ff @(posedge clk_i) begin
    aq[0] <= a_i;
    bq[0] <= b_i;
    for (int i = 1; i < MM_LAT; i++) begin
      aq[i] <= aq[i-1];
      bq[i] <= bq[i-1];
    end
  end

  logic  lv;
  opnd_t la, lb;
  assign lv = vq[MM_LAT-1];
  assign la = aq[MM_LAT-1];
  assign lb = bq[MM_LAT-1];

  assert_valid_latency_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o == lv);

  assert_reset_quiet_R8: assert property (@(posedge clk_i)
    (!rst_ni && $past(!rst_ni)) |-> !out_valid_o);

  assert_both_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lv && la == '0 && lb == '0) |-> prod_o == 16'h0001);

  assert_zero_code_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lv && la == '0 && lb != '0) |-> prod_o == 16'(17'h10001 - {1'b0, lb}));

  assert_unit_pass_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lv && la == 16'h0001 && lb != '0) |-> prod_o == lb);

  assert_wrap_code_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lv && la == 16'h0002 && lb == 16'h8000) |-> prod_o == 16'h0000);
endmodule

bind mm_mul65537 mm_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .a_i         (a_i),
  .b_i         (b_i),
  .out_valid_o (out_valid_o),
  .prod_o      (prod_o)
);

// File: tb/mm_mul65537_tb.sv
module mm_mul65537_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid_i = 1'b0;
  logic [15:0] a_i = '0;
  logic [15:0] b_i = '0;
  logic        out_valid_o;
  logic [15:0] prod_o;

  mm_mul65537 u_dut (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (in_valid_i),
    .a_i         (a_i),
    .b_i         (b_i),
    .out_valid_o (out_valid_o),
    .prod_o      (prod_o)
  );

  always #5 clk_i = ~clk_i;

  int    n_chk = 0;
  int    n_err = 0;
  bit    done = 1'b0;
  bit    b2b = 1'b0;
  int    cyc = 0;
  logic        hv   [8];
  logic [15:0] ha   [8];
  logic [15:0] hb   [8];
  logic [15:0] hexp [8];

  function automatic logic [15:0] ref_mul(logic [15:0] a, logic [15:0] b);
    longint unsigned ea, eb, r;
    ea = (a == 16'h0) ? 65536 : longint'(a);
    eb = (b == 16'h0) ? 65536 : longint'(b);
    r  = (ea * eb) % 65537;
    return (r == 65536) ? 16'h0000 : 16'(r);
  endfunction

  function automatic string req_of(logic [15:0] a, logic [15:0] b, logic [15:0] e);
    if (a == 0 && b == 0) return "R3";
    if (a == 0 || b == 0) return "R2";
    if (e == 0)           return "R4";
    if (a == 1 || b == 1) return "R5";
    return "R1";
  endfunction

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic clear_hist();
    for (int i = 0; i < 8; i++) hv[i] = 1'b0;
    cyc = 0;
  endtask

  // sample outputs of the pair driven four negedges earlier, then drive
  task automatic step(bit v, logic [15:0] a, logic [15:0] b);
    int s;
    @(negedge clk_i);
    s = (cyc + 4) % 8;
    check(out_valid_o == hv[s], b2b ? "R6" : "R7", "out_valid", 32'(out_valid_o), 32'(hv[s]));
    if (hv[s] && out_valid_o)
      check(prod_o == hexp[s], req_of(ha[s], hb[s], hexp[s]),
            $sformatf("prod a=%h b=%h", ha[s], hb[s]), 32'(prod_o), 32'(hexp[s]));
    in_valid_i = v;
    a_i = a;
    b_i = b;
    hv[cyc % 8]   = v;
    ha[cyc % 8]   = a;
    hb[cyc % 8]   = b;
    hexp[cyc % 8] = ref_mul(a, b);
    cyc++;
  endtask

  function automatic logic [15:0] pick();
    int unsigned k = $urandom_range(0, 9);
    case (k)
      0: return 16'h0000;
      1: return 16'h0001;
      2: return 16'hFFFF;
      default: return 16'($urandom());
    endcase
  endfunction

  initial begin
    repeat (50000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL R7 watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [15:0] corner [6];
    int unsigned seed;
    seed = $urandom(32'd20240611);
    corner = '{16'h0000, 16'h0001, 16'h0002, 16'h8000, 16'h7FFF, 16'hFFFF};
    clear_hist();

    // R8: quiet during reset
    repeat (3) begin
      @(negedge clk_i);
      check(out_valid_o == 1'b0, "R8", "valid in reset", 32'(out_valid_o), 32'h0);
    end
    rst_ni = 1'b1;

    // R6: all corner pairs back to back
    b2b = 1'b1;
    for (int i = 0; i < 6; i++)
      for (int j = 0; j < 6; j++)
        step(1'b1, corner[i], corner[j]);
    step(1'b1, 16'h8000, 16'h0002);
    step(1'b1, 16'hFFFF, 16'hFFFF);
    repeat (6) step(1'b0, 16'h0, 16'h0);
    b2b = 1'b0;

    // R8: reset with results in flight
    repeat (3) step(1'b1, pick(), pick());
    @(negedge clk_i);
    rst_ni = 1'b0;
    in_valid_i = 1'b0;
    @(negedge clk_i);
    check(out_valid_o == 1'b0, "R8", "valid after mid reset", 32'(out_valid_o), 32'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    clear_hist();
    for (int i = 0; i < 6; i++) begin
      step(1'b0, 16'h0, 16'h0);
      check(out_valid_o == 1'b0, "R8", "stale result after reset", 32'(out_valid_o), 32'h0);
    end

    // R1 and friends: random traffic with gaps
    for (int n = 0; n < 1500; n++)
      step($urandom_range(0, 3) != 0, pick(), pick());
    repeat (6) step(1'b0, 16'h0, 16'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule